// File: doc/BRIEF.md
# Debug Matchpoint Comparator Unit

The unit watches the memory and fetch traffic of a processor core. It decides whether each access should stop the core for debugging. Every access arrives as a valid strobe, a 3-bit access kind and a 32-bit value. The value is an effective address for fetch and address kinds, and the transferred word for data kinds. A bank of eight matchpoints each holds a control word and a comparison value. A matchpoint that is armed and selects the current kind of access compares the access value against its value register and reports a hit.

Software or a debug host programs the unit through a synchronous register write port. Two mode registers control it. The first holds a single-step enable, which turns every valid instruction fetch into a break request. The second holds two enables, break-generation and counter-assignment. Matchpoints are evaluated only while at least one of these two enables is set. The hit flags and the break request are combinational functions of the access inputs and the stored registers.

Top module: `dbg_matchpoint_unit`

## Requirements
- R1: All registers are zero after reset, and a write takes effect at the clock edge where `wr_en` is high. The address map is: 0 is mode register A (bit 0 is single-step), 1 is mode register B (bit 0 is break-generation, bit 1 is counter-assignment), 8+i is the control word of matchpoint i, and 16+i is the value of matchpoint i.
- R2: When single-step is set, a valid access of kind 0 (instruction fetch) raises `brk_req`, whatever the matchpoint state. Other kinds do not raise a break through single-step.
- R3: When both enables in mode register B are clear, every hit flag is 0 and no break comes from matchpoints. Either enable alone is enough to enable evaluation.
- R4: A matchpoint can hit only when its arm bit (control bit 0) is set and its watch-type field (control bits 7:5) is nonzero.
- R5: Access kinds are encoded 0 fetch, 1 load address, 2 store address, 3 load data, 4 store data. Watch types are encoded 1 fetch address, 2 load address, 3 store address, 4 load data, 5 store data, 6 load-or-store address, 7 load-or-store data. A matchpoint applies to an access when its type names that kind, or names the load-or-store form that covers it.
- R6: The condition field (control bits 3:1) selects 0 masked, 1 equal, 2 less-than, 3 less-or-equal, 4 greater-than, 5 greater-or-equal, 6 not-equal. The access value is the left operand. Code 7 never hits.
- R7: When control bit 4 is set, ordered conditions compare both operands as signed two's-complement numbers. When it is clear, they compare as unsigned numbers.
- R8: With the masked condition, a hit occurs exactly when the bitwise AND of the access value and the value register is nonzero.
- R9: No hit and no break occur while `acc_valid` is low. `brk_req` is the OR of all hit flags and the single-step fetch condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | Access strobe |
| acc_kind | input | 3 | Access kind code |
| acc_value | input | 32 | Access address or data |
| hit | output | 8 | Per-matchpoint hit flags |
| brk_req | output | 1 | Break request to the core |

## Verification
The assertions check the following on every cycle:
- No hit appears without a valid access or while evaluation is disabled.
- Every hit is covered by the break request.
- An armed single-step fetch always breaks.
- A hit flag is never raised by an unarmed or untyped matchpoint.
- A mode-register write lands one edge later.

Only the bench's scenarios can show the rest:
- The correctness of each comparison: signed against unsigned ordering near the sign boundary, masked overlap, and the never-hit code.
- The routing of each access kind to the watch types that cover it.
- Register addressing across matchpoint slots.

// File: rtl/dbg_mp_pkg.sv
package dbg_mp_pkg;

    typedef enum logic [2:0] {
        AK_FETCH  = 3'd0,
        AK_LDADDR = 3'd1,
        AK_STADDR = 3'd2,
        AK_LDDATA = 3'd3,
        AK_STDATA = 3'd4
    } acc_kind_e;

    typedef enum logic [2:0] {
        WT_OFF   = 3'd0,
        WT_FETCH = 3'd1,
        WT_LDA   = 3'd2,
        WT_STA   = 3'd3,
        WT_LDD   = 3'd4,
        WT_STD   = 3'd5,
        WT_LSA   = 3'd6,
        WT_LSD   = 3'd7
    } watch_type_e;

    typedef enum logic [2:0] {
        CC_MASK = 3'd0,
        CC_EQ   = 3'd1,
        CC_LT   = 3'd2,
        CC_LE   = 3'd3,
        CC_GT   = 3'd4,
        CC_GE   = 3'd5,
        CC_NE   = 3'd6,
        CC_NONE = 3'd7
    } cmp_cond_e;

    // Control word layout: [7:5] watch type, [4] signed, [3:1] condition, [0] arm
    typedef struct packed {
        watch_type_e wtype;
        logic        sgn;
        cmp_cond_e   cond;
        logic        arm;
    } mp_ctrl_t;

    localparam int CTRL_W = $bits(mp_ctrl_t);

endpackage

// File: rtl/dbg_mp_regs.sv
module dbg_mp_regs
    import dbg_mp_pkg::*;
#(
    parameter int NUM_MP = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic                            step_o,
    output logic [1:0]                      wp_en_o,
    output mp_ctrl_t [NUM_MP-1:0]           ctrl_o,
    output logic [NUM_MP-1:0][DATA_W-1:0]   val_o
);

    localparam int CTRL_BASE = (NUM_MP < 2) ? 2 : (1 << $clog2(NUM_MP));
    localparam int VAL_BASE  = 2 * CTRL_BASE;
    localparam logic [ADDR_W-1:0] A_MODE_A = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MODE_B = ADDR_W'(1);

    typedef struct packed {
        logic                          step;
        logic [1:0]                    wp_en;
        mp_ctrl_t [NUM_MP-1:0]         ctrl;
        logic [NUM_MP-1:0][DATA_W-1:0] val;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == A_MODE_A) regs_d.step  = wr_data[0];
            if (wr_addr == A_MODE_B) regs_d.wp_en = wr_data[1:0];
            for (int i = 0; i < NUM_MP; i++) begin
                if (wr_addr == ADDR_W'(CTRL_BASE + i))
                    regs_d.ctrl[i] = mp_ctrl_t'(wr_data[CTRL_W-1:0]);
                if (wr_addr == ADDR_W'(VAL_BASE + i))
                    regs_d.val[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign step_o  = regs_q.step;
    assign wp_en_o = regs_q.wp_en;
    assign ctrl_o  = regs_q.ctrl;
    assign val_o   = regs_q.val;

    AST_MODE_A_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MODE_A) |=> (step_o == $past(wr_data[0]))); // R1
    AST_MODE_B_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MODE_B) |=> (wp_en_o == $past(wr_data[1:0]))); // R1
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !$past(!rst_n)) |=> $stable(wp_en_o)); // R1

endmodule

// File: rtl/dbg_mp_cmp.sv
module dbg_mp_cmp
    import dbg_mp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              acc_valid,
    input  logic [2:0]        acc_kind,
    input  logic [DATA_W-1:0] acc_value,
    input  logic              eval_en,
    input  mp_ctrl_t          ctrl,
    input  logic [DATA_W-1:0] ref_val,
    output logic              hit_o
);

    logic applies;
    logic eq, lt, cmp_ok;

    always_comb begin
        unique case (acc_kind)
            AK_FETCH:  applies = (ctrl.wtype == WT_FETCH);
            AK_LDADDR: applies = (ctrl.wtype == WT_LDA) || (ctrl.wtype == WT_LSA);
            AK_STADDR: applies = (ctrl.wtype == WT_STA) || (ctrl.wtype == WT_LSA);
            AK_LDDATA: applies = (ctrl.wtype == WT_LDD) || (ctrl.wtype == WT_LSD);
            AK_STDATA: applies = (ctrl.wtype == WT_STD) || (ctrl.wtype == WT_LSD);
            default:   applies = 1'b0;
        endcase
    end

    always_comb begin
        eq = (acc_value == ref_val);
        lt = ctrl.sgn ? ($signed(acc_value) < $signed(ref_val))
                      : (acc_value < ref_val);
        unique case (ctrl.cond)
            CC_MASK: cmp_ok = |(acc_value & ref_val);
            CC_EQ:   cmp_ok = eq;
            CC_LT:   cmp_ok = lt;
            CC_LE:   cmp_ok = lt || eq;
            CC_GT:   cmp_ok = !(lt || eq);
            CC_GE:   cmp_ok = !lt;
            CC_NE:   cmp_ok = !eq;
            default: cmp_ok = 1'b0;
        endcase
    end

    assign hit_o = acc_valid && eval_en && ctrl.arm && (ctrl.wtype != WT_OFF)
                   && applies && cmp_ok;

endmodule

// File: rtl/dbg_matchpoint_unit.sv
module dbg_matchpoint_unit
    import dbg_mp_pkg::*;
#(
    parameter int NUM_MP = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic [2:0]        acc_kind,
    input  logic [DATA_W-1:0] acc_value,
    output logic [NUM_MP-1:0] hit,
    output logic              brk_req
);

    logic                          step;
    logic [1:0]                    wp_en;
    mp_ctrl_t [NUM_MP-1:0]         ctrl;
    logic [NUM_MP-1:0][DATA_W-1:0] val;
    logic                          eval_en;
    logic                          step_brk;

    dbg_mp_regs #(
        .NUM_MP (NUM_MP),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .step_o  (step),
        .wp_en_o (wp_en),
        .ctrl_o  (ctrl),
        .val_o   (val)
    );

    assign eval_en  = |wp_en;
    assign step_brk = acc_valid && step && (acc_kind == AK_FETCH);

    for (genvar g = 0; g < NUM_MP; g++) begin : g_mp
        dbg_mp_cmp #(
            .DATA_W (DATA_W)
        ) u_cmp (
            .acc_valid (acc_valid),
            .acc_kind  (acc_kind),
            .acc_value (acc_value),
            .eval_en   (eval_en),
            .ctrl      (ctrl[g]),
            .ref_val   (val[g]),
            .hit_o     (hit[g])
        );

        AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |-> (ctrl[g].arm && ctrl[g].wtype != WT_OFF)); // R4
    end

    assign brk_req = step_brk || (|hit);

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> acc_valid); // R9
    AST_BRK_COVERS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> brk_req); // R9
    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> (wp_en != 2'b00)); // R3
    AST_STEP_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && step && acc_kind == 3'd0) |-> brk_req); // R2

endmodule

// File: tb/dbg_matchpoint_unit_test.sv
module dbg_matchpoint_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_kind = '0;
    logic [31:0] acc_value = '0;
    logic [7:0]  hit;
    logic        brk_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbg_matchpoint_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_value(acc_value), .hit(hit), .brk_req(brk_req)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  wtype;
        logic        sgn;
        logic [2:0]  cond;
        logic        arm;
        logic [31:0] val;
        logic [2:0]  kind;
        logic [31:0] data;
        logic        exp;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{4'd5, 3'd1, 1'b0, 3'd1, 1'b1, 32'h1000, 3'd0, 32'h1000, 1'b1},
        '{4'd6, 3'd1, 1'b0, 3'd1, 1'b1, 32'h1000, 3'd0, 32'h1004, 1'b0},
        '{4'd5, 3'd1, 1'b0, 3'd1, 1'b1, 32'h1000, 3'd1, 32'h1000, 1'b0},
        '{4'd5, 3'd2, 1'b0, 3'd1, 1'b1, 32'h2000, 3'd1, 32'h2000, 1'b1},
        '{4'd5, 3'd2, 1'b0, 3'd1, 1'b1, 32'h2000, 3'd2, 32'h2000, 1'b0},
        '{4'd5, 3'd6, 1'b0, 3'd1, 1'b1, 32'h3000, 3'd2, 32'h3000, 1'b1},
        '{4'd5, 3'd6, 1'b0, 3'd1, 1'b1, 32'h3000, 3'd1, 32'h3000, 1'b1},
        '{4'd5, 3'd6, 1'b0, 3'd1, 1'b1, 32'h3000, 3'd3, 32'h3000, 1'b0},
        '{4'd5, 3'd7, 1'b0, 3'd1, 1'b1, 32'h5,    3'd3, 32'h5,    1'b1},
        '{4'd5, 3'd7, 1'b0, 3'd1, 1'b1, 32'h5,    3'd4, 32'h5,    1'b1},
        '{4'd5, 3'd4, 1'b0, 3'd1, 1'b1, 32'h5,    3'd4, 32'h5,    1'b0},
        '{4'd5, 3'd5, 1'b0, 3'd1, 1'b1, 32'h5,    3'd4, 32'h5,    1'b1},
        '{4'd5, 3'd3, 1'b0, 3'd1, 1'b1, 32'h40,   3'd2, 32'h40,   1'b1},
        '{4'd7, 3'd4, 1'b0, 3'd2, 1'b1, 32'h10,   3'd3, 32'hFFFF_FFF0, 1'b0},
        '{4'd7, 3'd4, 1'b1, 3'd2, 1'b1, 32'h10,   3'd3, 32'hFFFF_FFF0, 1'b1},
        '{4'd7, 3'd4, 1'b1, 3'd5, 1'b1, 32'h0,    3'd3, 32'h8000_0000, 1'b0},
        '{4'd7, 3'd4, 1'b0, 3'd5, 1'b1, 32'h0,    3'd3, 32'h8000_0000, 1'b1},
        '{4'd7, 3'd4, 1'b1, 3'd4, 1'b1, 32'hFFFF_FFFF, 3'd3, 32'h0, 1'b1},
        '{4'd8, 3'd4, 1'b0, 3'd0, 1'b1, 32'hF0,   3'd3, 32'h100,  1'b0},
        '{4'd8, 3'd4, 1'b1, 3'd0, 1'b1, 32'hF0,   3'd3, 32'h180,  1'b1},
        '{4'd6, 3'd4, 1'b0, 3'd3, 1'b1, 32'h20,   3'd3, 32'h20,   1'b1},
        '{4'd6, 3'd4, 1'b0, 3'd4, 1'b1, 32'h20,   3'd3, 32'h20,   1'b0},
        '{4'd6, 3'd4, 1'b0, 3'd6, 1'b1, 32'h1,    3'd3, 32'h2,    1'b1},
        '{4'd6, 3'd4, 1'b0, 3'd2, 1'b1, 32'h2,    3'd3, 32'h1,    1'b1},
        '{4'd6, 3'd4, 1'b0, 3'd7, 1'b1, 32'h5,    3'd3, 32'h5,    1'b0},
        '{4'd4, 3'd4, 1'b0, 3'd1, 1'b0, 32'h5,    3'd3, 32'h5,    1'b0},
        '{4'd4, 3'd0, 1'b0, 3'd1, 1'b1, 32'h5,    3'd3, 32'h5,    1'b0}
    };

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive an access just after a falling edge and sample 1 ns later.
    task automatic access(input logic v, input logic [2:0] k, input logic [31:0] d);
        acc_valid = v; acc_kind = k; acc_value = d;
        #1;
    endtask

    task automatic idle();
        acc_valid = 1'b0; acc_kind = 3'd0; acc_value = '0;
    endtask

    function automatic logic [31:0] mk(input logic [2:0] t, input logic s,
                                       input logic [2:0] c, input logic a);
        return {24'd0, t, s, c, a};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, nothing armed, even a valid fetch breaks nothing
        access(1'b1, 3'd0, 32'h0);
        chk("R1", "reset hit", {24'd0, hit}, 32'd0);
        chk("R1", "reset brk", {31'd0, brk_req}, 32'd0);
        idle();

        // Table walk on matchpoint 0, break-generation enable on
        wr(5'd1, 32'h1);
        for (int i = 0; i < NV; i++) begin
            wr(5'd8, mk(VEC[i].wtype, VEC[i].sgn, VEC[i].cond, VEC[i].arm));
            wr(5'd16, VEC[i].val);
            access(1'b1, VEC[i].kind, VEC[i].data);
            chk(tag(VEC[i].req), $sformatf("vec %0d hit", i), {24'd0, hit}, {31'd0, VEC[i].exp});
            chk(tag(VEC[i].req), $sformatf("vec %0d brk", i), {31'd0, brk_req}, {31'd0, VEC[i].exp});
            idle();
        end

        // R9: matching access without valid
        wr(5'd8, mk(3'd4, 1'b0, 3'd1, 1'b1));
        wr(5'd16, 32'h77);
        access(1'b0, 3'd3, 32'h77);
        chk("R9", "invalid hit", {24'd0, hit}, 32'd0);
        chk("R9", "invalid brk", {31'd0, brk_req}, 32'd0);
        idle();

        // R3: both enables clear blocks matchpoints
        wr(5'd1, 32'h0);
        @(negedge clk);
        access(1'b1, 3'd3, 32'h77);
        chk("R3", "disabled hit", {24'd0, hit}, 32'd0);
        chk("R3", "disabled brk", {31'd0, brk_req}, 32'd0);
        idle();
        // R3: counter-assignment enable alone re-enables evaluation
        wr(5'd1, 32'h2);
        access(1'b1, 3'd3, 32'h77);
        chk("R3", "counter-only hit", {24'd0, hit}, 32'h1);
        chk("R3", "counter-only brk", {31'd0, brk_req}, 32'h1);
        idle();

        // R1: matchpoint 7 via its own slots; two matchpoints hit together (R9)
        wr(5'd15, mk(3'd7, 1'b0, 3'd1, 1'b1));
        wr(5'd23, 32'h77);
        access(1'b1, 3'd4, 32'h77);
        chk("R1", "slot 7 store-data hit", {24'd0, hit}, 32'h80);
        idle();
        access(1'b1, 3'd3, 32'h77);
        chk("R9", "two hits", {24'd0, hit}, 32'h81);
        chk("R9", "two hits brk", {31'd0, brk_req}, 32'h1);
        idle();

        // R2: single-step breaks fetches only, with matchpoints disabled
        wr(5'd1, 32'h0);
        wr(5'd0, 32'h1);
        access(1'b1, 3'd0, 32'hDEAD_0000);
        chk("R2", "step fetch brk", {31'd0, brk_req}, 32'h1);
        chk("R2", "step fetch hit", {24'd0, hit}, 32'd0);
        idle();
        access(1'b1, 3'd1, 32'hDEAD_0000);
        chk("R2", "step load addr brk", {31'd0, brk_req}, 32'd0);
        idle();
        access(1'b0, 3'd0, 32'h0);
        chk("R2", "step no valid brk", {31'd0, brk_req}, 32'd0);
        idle();

        // R1: reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wr(5'd1, 32'h1);
        access(1'b1, 3'd0, 32'h0);
        chk("R1", "after reset step brk", {31'd0, brk_req}, 32'd0);
        idle();
        access(1'b1, 3'd3, 32'h77);
        chk("R1", "after reset hit", {24'd0, hit}, 32'd0);
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule